// File: doc/BRIEF.md
# Two-part DRAM command encoder

This block turns the command of one DFI phase into the command/address stream for a low-pin-count DRAM. That DRAM takes a single chip-select line and a 6-bit command/address bus. Each DRAM command is built from one or two subcommands, and every subcommand lasts two DRAM clock cycles. The encoder therefore produces a window of four DRAM cycles per DFI phase.

The four cycles come out in parallel, one registered cycle after the DFI inputs are presented. A serializer downstream can shift them onto the pads. Activate, read, write and mode register write each take both subcommand slots. Precharge, refresh and ZQ calibration take only the first slot. A DFI ZQ calibration is remapped to a multipurpose command. A mode register write packs the register address and the data value into the DFI address field. A static select input decides whether DFI writes become plain writes or masked writes.

Top module: `dfi_cmd_encoder`

## Requirements
- R1: While `rst_n` is low, every rising edge clears `cs_o`, `ca_o` and `long_o` to zero, whatever the command inputs are.
- R2: The window for a phase appears on the outputs at the first rising edge after the inputs are sampled. Back-to-back phases produce back-to-back windows. A phase with `dfi_cs_n` high, or with ras_n/cas_n/we_n = 1/1/1, yields `cs_o`=0, `ca_o`=0 and `long_o`=0.
- R3: Slot k of the window is `cs_o[k]` and `ca_o[6k+5:6k]`. A four-cycle command drives `cs_o`=4'b0101 and `long_o`=1. A two-cycle command drives `cs_o`=4'b0001, `long_o`=0, and zero in `ca_o[23:12]`. Within a subcommand, the opcode sits in CA[3:0] of its first cycle.
- R4: Activate (ras_n/cas_n/we_n = 0/1/1) takes row = `dfi_address[12:0]` and bank = `dfi_bank`. Cycle 0 = {row[12:11], 4'h1}. Cycle 1 = row[10:5]. Cycle 2 = {row[4:3], 4'h2}. Cycle 3 = {row[2:0], bank}.
- R5: Read (1/0/1) emits a read-first subcommand and then a column subcommand, with col = `dfi_address[7:0]`. Cycle 0 = {2'b00, 4'h3}. Cycle 1 = {3'b000, bank}. Cycle 2 = {col[7:6], 4'h6}. Cycle 3 = col[5:0].
- R6: Write (1/0/0) is encoded like a read, but cycle 0 carries opcode 4'h5 when `masked_wr_en` is 1 and opcode 4'h4 when it is 0.
- R7: Mode register write (0/0/0) takes MA = `dfi_address[15:8]` and value V = `dfi_address[7:0]`. Cycle 0 = {V[7:6], 4'h9}. Cycle 1 = MA[5:0]. Cycle 2 = {MA[7:6], 4'hA}. Cycle 3 = V[5:0]. `dfi_bank` has no effect on it.
- R8: ZQ calibration (1/1/0) becomes a two-cycle multipurpose command with OP = `dfi_address[6:0]`. Cycle 0 = {OP[6], 1'b0, 4'hB}. Cycle 1 = OP[5:0].
- R9: Precharge (0/1/0) is two cycles. Cycle 0 = {`dfi_address[10]`, 1'b0, 4'h7}. Cycle 1 = {3'b000, bank}. Refresh (0/0/1) is two cycles, with cycle 0 = {2'b00, 4'h8} and cycle 1 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dfi_cs_n | input | 1 | DFI chip select, active low |
| dfi_ras_n | input | 1 | DFI row strobe, active low |
| dfi_cas_n | input | 1 | DFI column strobe, active low |
| dfi_we_n | input | 1 | DFI write enable, active low |
| dfi_bank | input | 3 | DFI bank |
| dfi_address | input | 16 | DFI address; also carries MA, value and MPC operand |
| masked_wr_en | input | 1 | Static: 1 selects masked write for DFI writes |
| cs_o | output | 4 | Chip select for DRAM cycles 0..3 |
| ca_o | output | 24 | CA bus for DRAM cycles 0..3, cycle k in bits 6k+5:6k |
| long_o | output | 1 | 1 when all four cycles are used, 0 for two or none |

## Verification
The bench drives mode register writes that differ only in `dfi_bank`. An encoder that borrowed the bank for the register address, as older command paths do, would produce different `ca_o` words for them. The masked-write select is flipped under the same write command, which catches an opcode that ignores it or has the two opcodes swapped. Commands with `dfi_cs_n` high but otherwise valid strobes check that a deselected phase cannot leak. Back-to-back phases expose any extra register stage or stale operand. Operands with alternating and extreme bit patterns show slices that are shifted or misordered across the two cycles of a subcommand.

// File: rtl/dfi_cmd_encoder.sv
module dfi_cmd_encoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dfi_cs_n,
  input  logic        dfi_ras_n,
  input  logic        dfi_cas_n,
  input  logic        dfi_we_n,
  input  logic [2:0]  dfi_bank,
  input  logic [15:0] dfi_address,
  input  logic        masked_wr_en,
  output logic [3:0]  cs_o,
  output logic [23:0] ca_o,
  output logic        long_o
);
  localparam logic [3:0] OP_ACT1 = 4'h1, OP_ACT2 = 4'h2, OP_RD1 = 4'h3, OP_WR1 = 4'h4,
                         OP_MWR1 = 4'h5, OP_CAS2 = 4'h6, OP_PRE = 4'h7, OP_REF = 4'h8,
                         OP_MRW1 = 4'h9, OP_MRW2 = 4'hA, OP_MPC = 4'hB;

  logic [5:0] c0, c1, c2, c3;
  logic       hit, lng;

  wire [12:0] row = dfi_address[12:0];
  wire [7:0]  col = dfi_address[7:0];
  wire [7:0]  ma  = dfi_address[15:8];
  wire [7:0]  val = dfi_address[7:0];
  wire [6:0]  mop = dfi_address[6:0];

  always_comb begin
    c0 = '0; c1 = '0; c2 = '0; c3 = '0;
    hit = 1'b0; lng = 1'b0;
    if (!dfi_cs_n) begin
      case ({dfi_ras_n, dfi_cas_n, dfi_we_n})
        3'b011: begin
          c0 = {row[12:11], OP_ACT1}; c1 = row[10:5];
          c2 = {row[4:3], OP_ACT2};   c3 = {row[2:0], dfi_bank};
          hit = 1'b1; lng = 1'b1;
        end
        3'b101: begin
          c0 = {2'b00, OP_RD1};       c1 = {3'b000, dfi_bank};
          c2 = {col[7:6], OP_CAS2};   c3 = col[5:0];
          hit = 1'b1; lng = 1'b1;
        end
        3'b100: begin
          c0 = {2'b00, masked_wr_en ? OP_MWR1 : OP_WR1};
          c1 = {3'b000, dfi_bank};
          c2 = {col[7:6], OP_CAS2};   c3 = col[5:0];
          hit = 1'b1; lng = 1'b1;
        end
        3'b000: begin
          c0 = {val[7:6], OP_MRW1};   c1 = ma[5:0];
          c2 = {ma[7:6], OP_MRW2};    c3 = val[5:0];
          hit = 1'b1; lng = 1'b1;
        end
        3'b010: begin
          c0 = {dfi_address[10], 1'b0, OP_PRE}; c1 = {3'b000, dfi_bank};
          hit = 1'b1;
        end
        3'b001: begin
          c0 = {2'b00, OP_REF};
          hit = 1'b1;
        end
        3'b110: begin
          c0 = {mop[6], 1'b0, OP_MPC}; c1 = mop[5:0];
          hit = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_o   <= '0;
      ca_o   <= '0;
      long_o <= 1'b0;
    end else begin
      cs_o   <= {1'b0, lng, 1'b0, hit};
      ca_o   <= {c3, c2, c1, c0};
      long_o <= lng;
    end
  end
endmodule

module dfi_cmd_encoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        dfi_cs_n,
  input logic        dfi_ras_n,
  input logic        dfi_cas_n,
  input logic        dfi_we_n,
  input logic [15:0] dfi_address,
  input logic [3:0]  cs_o,
  input logic [23:0] ca_o,
  input logic        long_o
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (cs_o == 4'b0000 && ca_o == 24'h0 && !long_o));

  // R2
  deselect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(dfi_cs_n)) |-> (cs_o == 4'b0000 && ca_o == 24'h0 && !long_o));

  // R3
  long_cs_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    long_o |-> (cs_o == 4'b0101));

  // R3
  short_tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!long_o && cs_o != 4'b0000) |-> (cs_o == 4'b0001 && ca_o[23:12] == 12'h0));

  // R8
  zq_to_mpc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!dfi_cs_n && dfi_ras_n && dfi_cas_n && !dfi_we_n))
    |-> (!long_o && ca_o[3:0] == 4'hB && ca_o[11:6] == $past(dfi_address[5:0])));

  // R5
  read_is_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!dfi_cs_n && dfi_ras_n && !dfi_cas_n && dfi_we_n))
    |-> (long_o && ca_o[3:0] == 4'h3 && ca_o[15:12] == 4'h6));
endmodule

bind dfi_cmd_encoder dfi_cmd_encoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dfi_cs_n(dfi_cs_n), .dfi_ras_n(dfi_ras_n),
  .dfi_cas_n(dfi_cas_n), .dfi_we_n(dfi_we_n), .dfi_address(dfi_address),
  .cs_o(cs_o), .ca_o(ca_o), .long_o(long_o)
);

// File: tb/dfi_cmd_encoder_tb.sv
module dfi_cmd_encoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [2:0]  bank = '0;
  logic [15:0] addr = '0;
  logic        mwr = 1'b1;
  logic [3:0]  cs_o;
  logic [23:0] ca_o;
  logic        long_o;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  dfi_cmd_encoder u_dut (
    .clk(clk), .rst_n(rst_n), .dfi_cs_n(cs_n), .dfi_ras_n(ras_n), .dfi_cas_n(cas_n),
    .dfi_we_n(we_n), .dfi_bank(bank), .dfi_address(addr), .masked_wr_en(mwr),
    .cs_o(cs_o), .ca_o(ca_o), .long_o(long_o)
  );

  task automatic check(string tag, logic [3:0] ecs, logic [5:0] e0, logic [5:0] e1,
                       logic [5:0] e2, logic [5:0] e3, logic el);
    logic [23:0] eca;
    eca = {e3, e2, e1, e0};
    n_chk++;
    if (cs_o !== ecs || ca_o !== eca || long_o !== el) begin
      n_bad++;
      $display("FAIL %s: got cs=%b ca=%h long=%b, expected cs=%b ca=%h long=%b",
               tag, cs_o, ca_o, long_o, ecs, eca, el);
    end
  endtask

  task automatic drive(logic c, logic r, logic ca, logic w, logic [2:0] b, logic [15:0] a);
    @(negedge clk);
    cs_n = c; ras_n = r; cas_n = ca; we_n = w; bank = b; addr = a;
  endtask

  task automatic settle();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    drive(1'b0, 1'b0, 1'b1, 1'b1, 3'd5, 16'h1FFF);
    settle();
    check("R1 reset with activate pending", 4'b0000, 6'h0, 6'h0, 6'h0, 6'h0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_nop();
    drive(1'b0, 1'b1, 1'b1, 1'b1, 3'd7, 16'hFFFF); settle();
    check("R2 nop", 4'b0000, 6'h0, 6'h0, 6'h0, 6'h0, 1'b0);
    drive(1'b1, 1'b0, 1'b1, 1'b1, 3'd7, 16'hFFFF); settle();
    check("R2 deselected activate", 4'b0000, 6'h0, 6'h0, 6'h0, 6'h0, 1'b0);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 3'd2, 16'hABCD); settle();
    check("R2 deselected mrw", 4'b0000, 6'h0, 6'h0, 6'h0, 6'h0, 1'b0);
  endtask

  task automatic t_act(logic [2:0] b, logic [12:0] row);
    drive(1'b0, 1'b0, 1'b1, 1'b1, b, {3'b111, row}); settle();
    check("R4 R3 activate", 4'b0101, {row[12:11], 4'h1}, row[10:5],
          {row[4:3], 4'h2}, {row[2:0], b}, 1'b1);
  endtask

  task automatic t_read(logic [2:0] b, logic [7:0] col);
    drive(1'b0, 1'b1, 1'b0, 1'b1, b, {8'hA5, col}); settle();
    check("R5 read", 4'b0101, {2'b00, 4'h3}, {3'b000, b}, {col[7:6], 4'h6}, col[5:0], 1'b1);
  endtask

  task automatic t_write(logic m, logic [2:0] b, logic [7:0] col);
    @(negedge clk); mwr = m;
    drive(1'b0, 1'b1, 1'b0, 1'b0, b, {8'h00, col}); settle();
    check(m ? "R6 masked write" : "R6 plain write", 4'b0101, {2'b00, m ? 4'h5 : 4'h4},
          {3'b000, b}, {col[7:6], 4'h6}, col[5:0], 1'b1);
  endtask

  task automatic t_mrw(logic [7:0] ma, logic [7:0] v);
    for (int b = 0; b < 8; b += 7) begin
      drive(1'b0, 1'b0, 1'b0, 1'b0, 3'(b), {ma, v}); settle();
      check("R7 mode register write, bank ignored", 4'b0101, {v[7:6], 4'h9}, ma[5:0],
            {ma[7:6], 4'hA}, v[5:0], 1'b1);
    end
  endtask

  task automatic t_zq(logic [6:0] op);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 3'd3, {9'h1FF, op}); settle();
    check("R8 R3 zq as mpc", 4'b0001, {op[6], 1'b0, 4'hB}, op[5:0], 6'h0, 6'h0, 1'b0);
  endtask

  task automatic t_pre_ref();
    drive(1'b0, 1'b0, 1'b1, 1'b0, 3'd6, 16'h0400); settle();
    check("R9 precharge all", 4'b0001, {1'b1, 1'b0, 4'h7}, {3'b000, 3'd6}, 6'h0, 6'h0, 1'b0);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 16'hFBFF); settle();
    check("R9 precharge one", 4'b0001, {1'b0, 1'b0, 4'h7}, {3'b000, 3'd1}, 6'h0, 6'h0, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 3'd7, 16'hFFFF); settle();
    check("R9 refresh", 4'b0001, {2'b00, 4'h8}, 6'h0, 6'h0, 6'h0, 1'b0);
  endtask

  task automatic t_stream();
    drive(1'b0, 1'b0, 1'b1, 1'b1, 3'd4, 16'h0AAA);
    @(posedge clk); #1;
    check("R2 stream slot 1 activate", 4'b0101, {2'b01, 4'h1}, 6'b010101,
          {2'b01, 4'h2}, {3'b010, 3'd4}, 1'b1);
    cs_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b0; addr = 16'h0055;
    @(posedge clk); #1;
    check("R2 stream slot 2 mpc", 4'b0001, {1'b1, 1'b0, 4'hB}, 6'h15, 6'h0, 6'h0, 1'b0);
    cs_n = 1'b1;
    @(posedge clk); #1;
    check("R2 stream slot 3 idle", 4'b0000, 6'h0, 6'h0, 6'h0, 6'h0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_nop();
    t_act(3'd5, 13'h1555);
    t_act(3'd2, 13'h0AAA);
    t_read(3'd7, 8'hC3);
    t_read(3'd0, 8'h3C);
    t_write(1'b1, 3'd3, 8'h81);
    t_write(1'b0, 3'd3, 8'h81);
    t_mrw(8'h8B, 8'h5E);
    t_mrw(8'h41, 8'hC0);
    t_zq(7'h4F);
    t_zq(7'h30);
    t_pre_ref();
    t_stream();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule